// File: doc/BRIEF.md
# Address Translation Buffer with Two-Level Table Walker

This block turns 32-bit linear addresses into physical addresses. A small fully associative buffer of recent translations answers a lookup directly when it holds the page. When it does not, a hardware walker fetches the translation from a two-level page table in memory. It reads a directory entry first, then a second-level entry when one is needed. It stores the result in the buffer and answers the request.

The linear address is split into three fields. Bits 31:22 index the directory (1024 entries), bits 21:12 index a second-level table (1024 entries) and bits 11:0 are the byte offset. Table entries are 32 bits wide. Bit 0 is the present flag, bits 31:12 hold the frame base, and bit 7 of a directory entry marks a 4 MB page. That bit counts only while the large-page enable input is high. For a 4 MB page, bits 21:0 of the linear address pass straight through.

Requests use a valid/ready handshake and are served one at a time. Each request gets one response pulse carrying either an address or a fault flag. Table entries are fetched through a read port with one read outstanding.

Top module: `tlb_walker`

## Requirements
- R1: On a buffer hit, rsp_valid is high in the second cycle after the accepting edge, no memory read is made, and rsp_paddr comes from the cached entry.
- R2: On a miss with a 4 KB page, the first read address is {dir_base[31:12], va[31:22], 2'b00} and the second is {pde[31:12], va[21:12], 2'b00}. The result is {pte[31:12], va[11:0]}.
- R3: With pse_en high and a present directory entry that has bit 7 set, exactly one read is made. The result is {pde[31:22], va[21:0]}.
- R4: With pse_en low, bit 7 of a directory entry is ignored and the walk continues to the second level.
- R5: A directory entry with bit 0 clear gives rsp_fault=1 and rsp_paddr=0 after one read. Nothing is cached, so the same address walks again.
- R6: A second-level entry with bit 0 clear gives rsp_fault=1 and rsp_paddr=0 after two reads. Nothing is cached.
- R7: A successful walk caches the page. A 4 MB entry matches on va[31:22] only and a 4 KB entry matches on va[31:12]. When several entries match, the lowest index wins.
- R8: Fills go to the entries in round-robin order from entry 0. The 33rd distinct fill after a flush evicts the first page while the second page still hits.
- R9: Raising flush for one cycle invalidates every entry and returns the fill pointer to entry 0. A flush wins over a fill in the same cycle.
- R10: req_ready is low from the accepting edge until the response. rsp_valid lasts one cycle. mem_req stays high with a stable mem_addr until mem_rvalid.
- R11: After reset, req_ready=1, rsp_valid=0, mem_req=0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| pse_en | input | 1 | Enables 4 MB directory pages |
| dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Page not present |
| mem_req | output | 1 | Table entry read pending |
| mem_addr | output | 32 | Address of the table entry being read |
| mem_rvalid | input | 1 | Read data valid, ends the read |
| mem_rdata | input | 32 | Table entry read data |

## Verification
The assertions check the handshake rules on every cycle. These are the single-cycle response pulse, a steady read request until data returns, and no new acceptance while busy. They also check that a hit never starts a read, that a fault carries a zero address, that a large page ends the walk after one read, and that a flush empties the valid bits. Whether the returned address is right, the walk addresses, round-robin eviction, the fault paths leaving nothing cached, and matching large pages on the upper ten bits only can be shown only by the bench. It runs directed and random lookup sequences against a reference model of the table contents and buffer.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        pse_en,
  input  logic [31:0] dir_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_DIR, S_TBL, S_DONE} st_t;
  st_t st;

  logic [31:0] va_q, pde_q, paddr_q;
  logic        fault_q;
  logic [ENTRIES-1:0] ent_v, ent_lg;
  logic [19:0] ent_tag [ENTRIES];
  logic [19:0] ent_pfn [ENTRIES];
  logic [PTR_W-1:0] rr_q;

  logic        lk_hit;
  logic [31:0] lk_pa;
  logic        in_look, in_dir;
  logic        fill_en, fill_lg;
  logic [19:0] fill_tag, fill_pfn;

  assign in_look   = (st == S_LOOK);
  assign in_dir    = (st == S_DIR);
  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_fault = rsp_valid & fault_q;
  assign rsp_paddr = rsp_valid ? paddr_q : 32'h0;
  assign mem_req   = (st == S_DIR) || (st == S_TBL);
  assign mem_addr  = (st == S_TBL) ? {pde_q[31:12], va_q[21:12], 2'b00}
                                   : {dir_base[31:12], va_q[31:22], 2'b00};

  always_comb begin
    lk_hit = 1'b0;
    lk_pa  = 32'h0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_v[i] && (ent_lg[i] ? (ent_tag[i][19:10] == va_q[31:22])
                                 : (ent_tag[i] == va_q[31:12]))) begin
        lk_hit = 1'b1;
        lk_pa  = ent_lg[i] ? {ent_pfn[i][19:10], va_q[21:0]}
                           : {ent_pfn[i], va_q[11:0]};
      end
    end
  end

  assign fill_lg  = in_dir;
  assign fill_en  = mem_rvalid && mem_rdata[0] &&
                    ((in_dir && pse_en && mem_rdata[7]) || (st == S_TBL));
  assign fill_tag = fill_lg ? {va_q[31:22], 10'h0} : va_q[31:12];
  assign fill_pfn = fill_lg ? {mem_rdata[31:22], 10'h0} : mem_rdata[31:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= 32'h0;
      pde_q   <= 32'h0;
      paddr_q <= 32'h0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          st   <= S_LOOK;
        end
        S_LOOK: if (lk_hit) begin
          paddr_q <= lk_pa;
          fault_q <= 1'b0;
          st      <= S_DONE;
        end else begin
          st <= S_DIR;
        end
        S_DIR: if (mem_rvalid) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[0]) begin
            paddr_q <= 32'h0;
            fault_q <= 1'b1;
            st      <= S_DONE;
          end else if (pse_en && mem_rdata[7]) begin
            paddr_q <= {mem_rdata[31:22], va_q[21:0]};
            fault_q <= 1'b0;
            st      <= S_DONE;
          end else begin
            st <= S_TBL;
          end
        end
        S_TBL: if (mem_rvalid) begin
          fault_q <= ~mem_rdata[0];
          paddr_q <= mem_rdata[0] ? {mem_rdata[31:12], va_q[11:0]} : 32'h0;
          st      <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      ent_v <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      ent_v[rr_q]  <= 1'b1;
      ent_lg[rr_q] <= fill_lg;
      rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && fill_en) begin
      ent_tag[rr_q] <= fill_tag;
      ent_pfn[rr_q] <= fill_pfn;
    end
  end
endmodule

module tlb_walker_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               pse_en,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [31:0]        rsp_paddr,
  input logic               rsp_fault,
  input logic               mem_req,
  input logic [31:0]        mem_addr,
  input logic               mem_rvalid,
  input logic [31:0]        mem_rdata,
  input logic               in_look,
  input logic               in_dir,
  input logic               lk_hit,
  input logic [ENTRIES-1:0] ent_v
);
  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_look && lk_hit) |=> (rsp_valid && !mem_req)); // R1
  AST_LARGE_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dir && mem_rvalid && mem_rdata[0] && mem_rdata[7] && pse_en) |=> (rsp_valid && !mem_req)); // R3
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_paddr == 32'h0)); // R5
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
endmodule

bind tlb_walker tlb_walker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .pse_en(pse_en),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .in_look(in_look), .in_dir(in_dir), .lk_hit(lk_hit), .ent_v(ent_v)
);

// File: tb/tb_tlb_walker.sv
module tb_tlb_walker;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int N = 32;

  logic clk = 0, rst_n = 0, flush = 0, pse_en = 0;
  logic req_valid = 0, mem_rvalid = 0;
  logic [31:0] req_vaddr = 0, mem_rdata = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;

  int checks = 0, fails = 0, nreads = 0, lat = 1;
  logic [31:0] rd_addr [2];
  bit done = 0;

  logic        m_v [N];
  logic        m_lg [N];
  logic [19:0] m_tag [N];
  logic [19:0] m_pfn [N];
  int          m_rr = 0;

  tlb_walker #(.ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pse_en(pse_en), .dir_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #2 clk = ~clk;

  function automatic logic [31:0] pde_f(input logic [9:0] d);
    if (d[2:0] == 3'd3) return 32'hABCD_E000;
    if (d[2:0] == 3'd5) return {(d ^ 10'h2a5) | 10'h200, 14'h0, 1'b1, 6'h0, 1'b1};
    return {4'h4, d, 6'h0, 12'h021};
  endfunction

  function automatic logic [31:0] pte_f(input logic [31:0] a);
    if (a[4:2] == 3'd5) return 32'h0000_0ffe;
    return {a[31:12] ^ {a[11:2], 10'h0} ^ 20'h13579, 12'h063};
  endfunction

  function automatic logic [31:0] memf(input logic [31:0] a);
    if (a[31:12] == BASE[31:12]) return pde_f(a[11:2]);
    return pte_f(a);
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (mem_req) begin
        if (lat == 0) begin
          if (nreads < 2) rd_addr[nreads] = mem_addr;
          mem_rdata  = memf(mem_addr);
          mem_rvalid = 1;
          nreads++;
          lat = $urandom_range(0, 2);
        end else lat--;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    model_flush();
  endtask

  task automatic model_fill(input logic lg, input logic [19:0] tg, input logic [19:0] pf);
    m_v[m_rr] = 1; m_lg[m_rr] = lg; m_tag[m_rr] = tg; m_pfn[m_rr] = pf;
    m_rr = (m_rr + 1) % N;
  endtask

  task automatic xlate(input logic [31:0] va, input string r, output int reads_out);
    logic hit, ef;
    logic [31:0] ep, pde, pte, a0, a1;
    int er, cyc;
    hit = 0; ep = 0; ef = 0; er = 0; a0 = 0; a1 = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && (m_lg[i] ? m_tag[i][19:10] == va[31:22] : m_tag[i] == va[31:12])) begin
        hit = 1;
        ep = m_lg[i] ? {m_pfn[i][19:10], va[21:0]} : {m_pfn[i], va[11:0]};
      end
    if (!hit) begin
      a0 = {BASE[31:12], va[31:22], 2'b00};
      pde = memf(a0);
      er = 1;
      if (!pde[0]) ef = 1;
      else if (pse_en && pde[7]) begin
        ep = {pde[31:22], va[21:0]};
        model_fill(1, {va[31:22], 10'h0}, {pde[31:22], 10'h0});
      end else begin
        a1 = {pde[31:12], va[21:12], 2'b00};
        pte = memf(a1);
        er = 2;
        if (!pte[0]) ef = 1;
        else begin
          ep = {pte[31:12], va[11:0]};
          model_fill(0, va[31:12], pte[31:12]);
        end
      end
    end
    @(negedge clk);
    nreads = 0; req_valid = 1; req_vaddr = va;
    @(posedge clk);
    #1 req_valid = 0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(!req_ready, {r, " R10 busy"}, 32'(req_ready), 0);
    end while (!rsp_valid && cyc < 100);
    chk(rsp_valid, {r, " response"}, 32'(rsp_valid), 1);
    chk(rsp_paddr == ep, {r, " paddr"}, rsp_paddr, ep);
    chk(rsp_fault == ef, {r, " fault"}, 32'(rsp_fault), 32'(ef));
    chk(nreads == er, {r, " reads"}, nreads, er);
    if (hit) chk(cyc == 2, {r, " R1 hit latency"}, cyc, 2);
    if (er >= 1) chk(rd_addr[0] == a0, {r, " dir addr"}, rd_addr[0], a0);
    if (er == 2) chk(rd_addr[1] == a1, {r, " tbl addr"}, rd_addr[1], a1);
    reads_out = nreads;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rd, t, cnt;
    logic [31:0] pages [33];
    model_flush();
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R11 ready", 32'(req_ready), 1);
    chk(rsp_valid == 0, "R11 rsp", 32'(rsp_valid), 0);
    chk(mem_req == 0, "R11 mem", 32'(mem_req), 0);
    rst_n = 1;

    xlate(32'h0000_1abc, "R11 empty", rd);
    xlate(32'h0000_2123, "R2", rd);
    chk(rd == 2, "R2 two reads", rd, 2);
    xlate(32'h0000_2fff, "R1", rd);
    chk(rd == 0, "R1 no read", rd, 0);

    pse_en = 1;
    xlate({10'd5, 10'd7, 12'h345}, "R3", rd);
    chk(rd == 1, "R3 one read", rd, 1);
    xlate({10'd5, 10'd300, 12'h001}, "R7 large", rd);
    chk(rd == 0, "R7 large hit", rd, 0);
    pse_en = 0;
    xlate({10'd13, 10'd2, 12'h010}, "R4", rd);
    chk(rd == 2, "R4 two reads", rd, 2);
    xlate({10'd0, 10'd3, 12'h0}, "R7 small miss", rd);
    chk(rd == 2, "R7 other small page walks", rd, 2);

    xlate({10'd3, 10'd1, 12'h0}, "R5", rd);
    xlate({10'd3, 10'd1, 12'h4}, "R5 again", rd);
    chk(rd == 1, "R5 not cached", rd, 1);
    xlate({10'd2, 10'd5, 12'h8}, "R6", rd);
    xlate({10'd2, 10'd5, 12'h8}, "R6 again", rd);
    chk(rd == 2, "R6 not cached", rd, 2);

    do_flush();
    xlate(32'h0000_2123, "R9", rd);
    chk(rd == 2, "R9 flushed walks", rd, 2);

    do_flush();
    cnt = 0; t = 0;
    while (cnt < 33) begin
      if (t % 8 != 5) begin pages[cnt] = {10'd1, 10'(t), 12'h0}; cnt++; end
      t++;
    end
    for (int k = 0; k < 33; k++) xlate(pages[k], "R8 fill", rd);
    xlate(pages[1] | 32'h44, "R8 survivor", rd);
    chk(rd == 0, "R8 second page hits", rd, 0);
    xlate(pages[0] | 32'h10, "R8 evicted", rd);
    chk(rd == 2, "R8 first page evicted", rd, 2);

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 39) == 0) do_flush();
      if ($urandom_range(0, 59) == 0) pse_en = ~pse_en;
      xlate({10'($urandom_range(0, 15)), 10'($urandom_range(0, 15)), 12'($urandom)}, "R7 random", rd);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule